// File: doc/BRIEF.md
# I2S Transmit Sample Unpacker

This block sits between a word-wide transmit buffer and an I2S serial output. Producers write 32-bit words into a small internal FIFO through a valid/ready handshake. An unpacking stage turns those words into left/right sample pairs, using a layout that depends on the channel width and on two mode inputs. One mode spreads a 24-bit stereo frame over two words, and the other sends a single channel. A serializer then shifts the pairs out as a bit clock, a word select and a data line, using a fixed clock divider.

While the transmitter is enabled it keeps running. If a frame is due and no complete pair is ready, it sends a frame of zeros, counts the underrun and realigns the word parity so that the next data word is again treated as a left sample. A watermark output asks for more data whenever the FIFO level is at or below a programmable threshold.

Top module: `i2s_tx_unpacker`

## Requirements
- R1: With a channel width of 4 to 16 bits, every word is one frame: left sample = word bits [15:0], right sample = word bits [31:16].
- R2: When the width N is smaller than the field that carries a sample, the bits of that field above N are never sent. Only the low N bits of each sample go out.
- R3: With a width of 17 to 24 and packing off, words alternate starting from even: an even word gives the left sample from bits [23:0] and the following odd word gives the right sample from bits [23:0].
- R4: With a width of 17 to 24 and packing on, the even word gives left[23:0] = bits [23:0] and right[7:0] = bits [31:24], and the next word gives right[23:8] = bits [15:0].
- R5: With a width of 25 to 32 in stereo, the even word is the whole left sample and the odd word is the whole right sample.
- R6: In single-channel mode, every word gives one left sample from its low N bits, and the right slot carries zeros.
- R7: Each slot lasts N bit clocks. Word select is 0 in the left slot and 1 in the right slot. The sample goes out MSB first, starting one bit clock after the word-select edge. Data and word select change only when the bit clock falls.
- R8: When a frame starts without a complete pair, that frame carries zeros, the underrun counter goes up by exactly one, and the bit clock and word select keep running.
- R9: Word parity returns to even whenever the transmitter is enabled and at each underrun. Any half-assembled pair is dropped at that point.
- R10: `wm_req` is 1 exactly when the FIFO level is less than or equal to `wm_thresh`.
- R11: After reset: `sck`=0, `ws`=1, `sd`=0, `fifo_level`=0, `underrun_cnt`=0, `in_ready`=1.
- R12: A word is accepted on a clock where `in_valid` and `in_ready` are both 1. `in_ready` is 0 while the level equals DEPTH, and a word offered in that state is not stored.
- R13: While `en` is 0, the bit clock stays low, word select stays high and no FIFO word is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Transmitter enable |
| chan_bits | input | 6 | Channel width N, 4 to 32 (values outside this range are clamped) |
| pack_mode | input | 1 | 24-bit stereo spread over two words (widths 17 to 24) |
| mono_mode | input | 1 | Single-channel operation |
| wm_thresh | input | LW (4) | Watermark threshold for the FIFO level |
| in_valid | input | 1 | Producer offers a word |
| in_data | input | 32 | Offered word |
| in_ready | output | 1 | FIFO can take a word |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Word select (0 = left, 1 = right) |
| sd | output | 1 | Serial data |
| wm_req | output | 1 | Watermark service request |
| fifo_level | output | LW (4) | Words held in the FIFO |
| underrun_cnt | output | CNT_W (16) | Underrun count since reset |

## Verification
The assertions assume that `chan_bits`, `pack_mode` and `mono_mode` are held steady while `en` is high, and that the divider parameter is at least two, so that a two-word pair can be fetched before the first frame. They also rely on the producer only seeing words stored when `in_ready` allows it. The stimulus changes the configuration only while the transmitter is disabled, and it loads each test's words before enabling, with one exception: the realignment test pushes words while the transmitter runs, during the underrun frame. A word is offered while the FIFO is full only in the back-pressure test, and there no check depends on the word being taken.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        FMT_HALF   = 2'd0,
        FMT_WIDE24 = 2'd1,
        FMT_PACK24 = 2'd2,
        FMT_FULL   = 2'd3
    } fmt_e;

    typedef struct packed {
        logic [WORD_W-1:0] left;
        logic [WORD_W-1:0] right;
    } pair_t;

    function automatic logic [5:0] clamp_bits(input logic [5:0] b);
        if (b < 6'd4)       return 6'd4;
        else if (b > 6'd32) return 6'd32;
        else                return b;
    endfunction

    function automatic fmt_e pick_fmt(input logic [5:0] b, input logic pack);
        if (b <= 6'd16)      return FMT_HALF;
        else if (b <= 6'd24) return pack ? FMT_PACK24 : FMT_WIDE24;
        else                 return FMT_FULL;
    endfunction

    function automatic logic [WORD_W-1:0] keep_low(input logic [WORD_W-1:0] v,
                                                   input logic [5:0] b);
        if (b >= 6'd32) return v;
        else            return v & ((32'd1 << b) - 32'd1);
    endfunction

endpackage

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic          do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_q];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        if (p == AW'(DEPTH - 1)) return '0;
        else                     return p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            level <= '0;
        end else begin
            if (do_push) wr_q <= bump(wr_q);
            if (do_pop)  rd_q <= bump(rd_q);
            case ({do_push, do_pop})
                2'b10:   level <= level + LW'(1);
                2'b01:   level <= level - LW'(1);
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/i2s_tx_unpack.sv
module i2s_tx_unpack
    import i2s_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [5:0]        bits,
    input  fmt_e              fmt,
    input  logic              mono,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_word,
    input  logic              take,
    input  logic              resync,
    output logic              fifo_pop,
    output logic              pair_valid,
    output pair_t             pair
);
    logic              odd_q;
    logic [WORD_W-1:0] lhold_q;
    logic [7:0]        rlo_q;

    logic              odd_n, valid_n;
    logic [WORD_W-1:0] lhold_n;
    logic [7:0]        rlo_n;
    pair_t             pair_n;

    assign fifo_pop = run && !resync && !pair_valid && !fifo_empty;

    always_comb begin
        odd_n   = odd_q;
        lhold_n = lhold_q;
        rlo_n   = rlo_q;
        valid_n = pair_valid;
        pair_n  = pair;
        if (take) valid_n = 1'b0;
        if (fifo_pop) begin
            if (mono) begin
                pair_n.left  = keep_low(fifo_word, bits);
                pair_n.right = '0;
                valid_n      = 1'b1;
            end else begin
                case (fmt)
                    FMT_HALF: begin
                        pair_n.left  = keep_low({16'b0, fifo_word[15:0]}, bits);
                        pair_n.right = keep_low({16'b0, fifo_word[31:16]}, bits);
                        valid_n      = 1'b1;
                    end
                    FMT_WIDE24: begin
                        if (!odd_q) begin
                            lhold_n = keep_low({8'b0, fifo_word[23:0]}, bits);
                            odd_n   = 1'b1;
                        end else begin
                            pair_n.left  = lhold_q;
                            pair_n.right = keep_low({8'b0, fifo_word[23:0]}, bits);
                            valid_n      = 1'b1;
                            odd_n        = 1'b0;
                        end
                    end
                    FMT_PACK24: begin
                        if (!odd_q) begin
                            lhold_n = keep_low({8'b0, fifo_word[23:0]}, bits);
                            rlo_n   = fifo_word[31:24];
                            odd_n   = 1'b1;
                        end else begin
                            pair_n.left  = lhold_q;
                            pair_n.right = keep_low({8'b0, fifo_word[15:0], rlo_q}, bits);
                            valid_n      = 1'b1;
                            odd_n        = 1'b0;
                        end
                    end
                    default: begin
                        if (!odd_q) begin
                            lhold_n = keep_low(fifo_word, bits);
                            odd_n   = 1'b1;
                        end else begin
                            pair_n.left  = lhold_q;
                            pair_n.right = keep_low(fifo_word, bits);
                            valid_n      = 1'b1;
                            odd_n        = 1'b0;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run || resync) begin
            odd_q      <= 1'b0;
            lhold_q    <= '0;
            rlo_q      <= '0;
            pair_valid <= 1'b0;
            pair       <= '0;
        end else begin
            odd_q      <= odd_n;
            lhold_q    <= lhold_n;
            rlo_q      <= rlo_n;
            pair_valid <= valid_n;
            pair       <= pair_n;
        end
    end
endmodule

// File: rtl/i2s_tx_serial.sv
module i2s_tx_serial
    import i2s_tx_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int CNT_W    = 16,
    localparam int DW      = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [5:0]       bits,
    input  logic             pair_valid,
    input  pair_t            pair,
    output logic             sck,
    output logic             ws,
    output logic             sd,
    output logic             take,
    output logic             starve,
    output logic [CNT_W-1:0] err_cnt
);
    logic [DW-1:0]     div_q;
    logic [4:0]        k_q;
    logic              first_q;
    logic [WORD_W-1:0] cur_q, rhold_q;
    logic [4:0]        last_k;
    logic              half_done, fall_tick, slot_end, to_left;

    assign last_k    = 5'(bits - 6'd1);
    assign half_done = (div_q == DW'(HALF_DIV - 1));
    assign fall_tick = run && sck && half_done;
    assign slot_end  = fall_tick && (first_q || (k_q == last_k));
    assign to_left   = slot_end && ws;
    assign take      = to_left && pair_valid;
    assign starve    = to_left && !pair_valid;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_q   <= '0;
            sck     <= 1'b0;
            ws      <= 1'b1;
            sd      <= 1'b0;
            k_q     <= '0;
            first_q <= 1'b1;
            cur_q   <= '0;
            rhold_q <= '0;
        end else if (half_done) begin
            div_q <= '0;
            sck   <= ~sck;
            if (slot_end) begin
                first_q <= 1'b0;
                k_q     <= '0;
                ws      <= ~ws;
                sd      <= cur_q[0];
                if (ws) begin
                    cur_q   <= pair_valid ? pair.left  : '0;
                    rhold_q <= pair_valid ? pair.right : '0;
                end else begin
                    cur_q <= rhold_q;
                end
            end else if (fall_tick) begin
                k_q <= k_q + 5'd1;
                sd  <= cur_q[last_k - k_q];
            end
        end else begin
            div_q <= div_q + DW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         err_cnt <= '0;
        else if (starve) err_cnt <= err_cnt + CNT_W'(1);
    end
endmodule

// File: rtl/i2s_tx_unpacker.sv
module i2s_tx_unpacker
    import i2s_tx_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int HALF_DIV = 2,
    parameter int CNT_W    = 16,
    localparam int LW      = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [5:0]       chan_bits,
    input  logic             pack_mode,
    input  logic             mono_mode,
    input  logic [LW-1:0]    wm_thresh,
    input  logic             in_valid,
    input  logic [31:0]      in_data,
    output logic             in_ready,
    output logic             sck,
    output logic             ws,
    output logic             sd,
    output logic             wm_req,
    output logic [LW-1:0]    fifo_level,
    output logic [CNT_W-1:0] underrun_cnt
);
    logic [5:0]        bits_c;
    fmt_e              fmt;
    logic              f_full, f_empty, f_pop;
    logic [WORD_W-1:0] f_word;
    logic              pv, take, starve;
    pair_t             pair;

    assign bits_c   = clamp_bits(chan_bits);
    assign fmt      = pick_fmt(bits_c, pack_mode);
    assign in_ready = !f_full;
    assign wm_req   = (fifo_level <= wm_thresh);

    i2s_tx_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
        .clk(clk), .rst(rst),
        .push(in_valid), .din(in_data),
        .pop(f_pop), .dout(f_word),
        .level(fifo_level), .full(f_full), .empty(f_empty)
    );

    i2s_tx_unpack u_unpack (
        .clk(clk), .rst(rst), .run(en),
        .bits(bits_c), .fmt(fmt), .mono(mono_mode),
        .fifo_empty(f_empty), .fifo_word(f_word),
        .take(take), .resync(starve),
        .fifo_pop(f_pop), .pair_valid(pv), .pair(pair)
    );

    i2s_tx_serial #(.HALF_DIV(HALF_DIV), .CNT_W(CNT_W)) u_serial (
        .clk(clk), .rst(rst), .run(en), .bits(bits_c),
        .pair_valid(pv), .pair(pair),
        .sck(sck), .ws(ws), .sd(sd),
        .take(take), .starve(starve), .err_cnt(underrun_cnt)
    );
endmodule

// File: rtl/i2s_tx_unpacker_chk.sv
module i2s_tx_unpacker_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 16,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             in_ready,
    input logic             sck,
    input logic             ws,
    input logic             sd,
    input logic [LW-1:0]    fifo_level,
    input logic [CNT_W-1:0] underrun_cnt
);
    // R7: data moves only on a falling bit-clock edge while running
    p_sd_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && $changed(sd)) |-> $fell(sck));

    // R7: word select moves only on a falling bit-clock edge while running
    p_ws_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && $changed(ws)) |-> $fell(sck));

    // R8: the underrun count moves only at a left-slot start
    p_err_with_frame_r8: assert property (@(posedge clk) disable iff (rst)
        $changed(underrun_cnt) |-> $fell(ws));

    // R13: disabled means the bit clock is parked low
    p_idle_sck_r13: assert property (@(posedge clk) disable iff (rst)
        !en |=> !sck);

    // R13: nothing leaves the FIFO while disabled
    p_idle_no_pop_r13: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> (fifo_level >= $past(fifo_level)));

    // R12: a full FIFO refuses words
    p_full_blocks_r12: assert property (@(posedge clk) disable iff (rst)
        (fifo_level == LW'(DEPTH)) |-> !in_ready);

    // R12: level moves by at most one word per clock
    p_level_step_r12: assert property (@(posedge clk) disable iff (rst)
        (fifo_level != $past(fifo_level)) |->
        ((fifo_level == $past(fifo_level) + LW'(1)) ||
         (fifo_level + LW'(1) == $past(fifo_level))));
endmodule

bind i2s_tx_unpacker i2s_tx_unpacker_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .en(en), .in_ready(in_ready),
    .sck(sck), .ws(ws), .sd(sd),
    .fifo_level(fifo_level), .underrun_cnt(underrun_cnt)
);

// File: tb/i2s_tx_unpacker_tb.sv
module i2s_tx_unpacker_tb;
    localparam int DEPTH  = 8;
    localparam int LW     = $clog2(DEPTH + 1);
    localparam int CNT_W  = 16;
    localparam int LOGMAX = 6 * 32 + 8;

    typedef struct packed {
        logic [5:0]            bits;
        logic                  pack;
        logic                  mono;
        logic [2:0]            nw;
        logic [2:0]            nfr;
        logic [0:3][31:0]      w;
        logic [0:5][31:0]      e;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VEC [NVEC] = '{
        {6'd16, 1'b0, 1'b0, 3'd2, 3'd2,
         32'h1234ABCD, 32'h80017FFE, 32'h0, 32'h0,
         32'hABCD, 32'h1234, 32'h7FFE, 32'h8001, 32'h0, 32'h0},
        {6'd8, 1'b0, 1'b0, 3'd2, 3'd2,
         32'hFF5AFFA5, 32'h12345678, 32'h0, 32'h0,
         32'hA5, 32'h5A, 32'h78, 32'h34, 32'h0, 32'h0},
        {6'd4, 1'b0, 1'b0, 3'd1, 3'd1,
         32'hFFF3FFFC, 32'h0, 32'h0, 32'h0,
         32'hC, 32'h3, 32'h0, 32'h0, 32'h0, 32'h0},
        {6'd24, 1'b0, 1'b0, 3'd4, 3'd2,
         32'hAA123456, 32'h55654321, 32'h00ABCDEF, 32'hFF000001,
         32'h123456, 32'h654321, 32'hABCDEF, 32'h000001, 32'h0, 32'h0},
        {6'd24, 1'b1, 1'b0, 3'd4, 3'd2,
         32'hEF123456, 32'hFFFFABCD, 32'h00000001, 32'h00008000,
         32'h123456, 32'hABCDEF, 32'h000001, 32'h800000, 32'h0, 32'h0},
        {6'd32, 1'b0, 1'b0, 3'd2, 3'd1,
         32'hDEADBEEF, 32'h01234567, 32'h0, 32'h0,
         32'hDEADBEEF, 32'h01234567, 32'h0, 32'h0, 32'h0, 32'h0},
        {6'd20, 1'b0, 1'b1, 3'd2, 3'd2,
         32'hFFF12345, 32'h000ABCDE, 32'h0, 32'h0,
         32'h12345, 32'h0, 32'hABCDE, 32'h0, 32'h0, 32'h0},
        {6'd12, 1'b0, 1'b1, 3'd3, 3'd3,
         32'hFFFF1ABC, 32'h00000123, 32'h00000FFF, 32'h0,
         32'hABC, 32'h0, 32'h123, 32'h0, 32'hFFF, 32'h0},
        {6'd17, 1'b0, 1'b0, 3'd3, 3'd1,
         32'h0001FFFF, 32'h00010000, 32'h00000005, 32'h0,
         32'h1FFFF, 32'h10000, 32'h0, 32'h0, 32'h0, 32'h0}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en = 1'b0;
    logic [5:0]       chan_bits = 6'd16;
    logic             pack_mode = 1'b0;
    logic             mono_mode = 1'b0;
    logic [LW-1:0]    wm_thresh = '0;
    logic             in_valid = 1'b0;
    logic [31:0]      in_data = '0;
    logic             in_ready, sck, ws, sd, wm_req;
    logic [LW-1:0]    fifo_level;
    logic [CNT_W-1:0] underrun_cnt;

    i2s_tx_unpacker #(.DEPTH(DEPTH), .HALF_DIV(2), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .en(en), .chan_bits(chan_bits),
        .pack_mode(pack_mode), .mono_mode(mono_mode), .wm_thresh(wm_thresh),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .sck(sck), .ws(ws), .sd(sd), .wm_req(wm_req),
        .fifo_level(fifo_level), .underrun_cnt(underrun_cnt)
    );

    always #5 clk = ~clk;

    int  nchk = 0, nfail = 0, cyc = 0, falls = 0, exp_err = 0, log_n = 0;
    bit  log_on = 0, log_started = 0, done = 0;
    logic sck_q = 1'b0, ws_q = 1'b1;
    logic log_ws [LOGMAX];
    logic log_sd [LOGMAX];

    // observer: bit-clock rises and left-slot starts
    always @(negedge clk) begin
        if (log_on && sck && !sck_q) begin
            if (!log_started && !ws) log_started = 1;
            if (log_started && log_n < LOGMAX) begin
                log_ws[log_n] = ws;
                log_sd[log_n] = sd;
                log_n++;
            end
        end
        if (!ws && ws_q) falls++;
        sck_q = sck;
        ws_q  = ws;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            nfail++;
            $display("FAIL watchdog: run did not complete (act=hung exp=done)");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; en = 1'b0; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_err = 0;
        @(negedge clk);
    endtask

    task automatic push(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [31:0] slot_val(input int s, input int n);
        logic [31:0] v = '0;
        for (int j = 1; j <= n; j++) v = {v[30:0], log_sd[s * n + j]};
        return v;
    endfunction

    function automatic int ws_errors(input int n);
        int bad = 0;
        for (int s = 0; s < 6; s++)
            for (int j = 0; j < n; j++)
                if (log_ws[s * n + j] !== s[0]) bad++;
        return bad;
    endfunction

    task automatic start_run();
        log_n = 0; log_started = 0; log_on = 1;
        @(negedge clk);
        en = 1'b1;
    endtask

    task automatic finish_run(input int n);
        while (log_n <= 6 * n) @(negedge clk);
        en = 1'b0;
        log_on = 0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int f0, n;
        string tag;
        vec_t v;

        do_reset();
        // R11: reset state
        chk("R11 sck", 32'(sck), 32'd0);
        chk("R11 ws", 32'(ws), 32'd1);
        chk("R11 sd", 32'(sd), 32'd0);
        chk("R11 level", 32'(fifo_level), 32'd0);
        chk("R11 underrun_cnt", 32'(underrun_cnt), 32'd0);
        chk("R11 in_ready", 32'(in_ready), 32'd1);
        chk("R10 wm_req at level 0 thresh 0", 32'(wm_req), 32'd1);

        // table of formats
        for (int i = 0; i < NVEC; i++) begin
            v = VEC[i];
            n = int'(v.bits);
            if (v.mono)            tag = "R6";
            else if (n <= 16)      tag = "R1 R2";
            else if (n <= 24)      tag = v.pack ? "R4" : "R3";
            else                   tag = "R5";
            @(negedge clk);
            chan_bits = v.bits; pack_mode = v.pack; mono_mode = v.mono;
            for (int k = 0; k < int'(v.nw); k++) push(v.w[k]);
            f0 = falls;
            start_run();
            finish_run(n);
            for (int s = 0; s < 6; s++) begin
                if (s < 2 * int'(v.nfr))
                    chk($sformatf("%s vec%0d slot%0d", tag, i, s), slot_val(s, n), v.e[s]);
                else
                    chk($sformatf("R8 zero slot vec%0d slot%0d", i, s), slot_val(s, n), v.e[s]);
            end
            chk($sformatf("R7 word select pattern vec%0d", i), 32'(ws_errors(n)), 32'd0);
            exp_err += (falls - f0) - int'(v.nfr);
            chk($sformatf("R8 underrun count vec%0d", i), 32'(underrun_cnt), 32'(exp_err));
        end

        // R9: parity realigns after an underrun drops a half pair
        do_reset();
        chan_bits = 6'd24; pack_mode = 1'b0; mono_mode = 1'b0;
        push(32'h00111111); push(32'h00222222); push(32'h00333333);
        f0 = falls;
        start_run();
        while (falls - f0 < 2) @(negedge clk);
        push(32'h00444444); push(32'h00555555);
        finish_run(24);
        chk("R9 slot0", slot_val(0, 24), 32'h111111);
        chk("R9 slot1", slot_val(1, 24), 32'h222222);
        chk("R9 dropped half pair slot2", slot_val(2, 24), 32'h0);
        chk("R9 dropped half pair slot3", slot_val(3, 24), 32'h0);
        chk("R9 realigned left slot4", slot_val(4, 24), 32'h444444);
        chk("R9 realigned right slot5", slot_val(5, 24), 32'h555555);
        exp_err += (falls - f0) - 2;
        chk("R8 underrun count after R9 run", 32'(underrun_cnt), 32'(exp_err));

        // R13: disabled transmitter holds still and consumes nothing
        do_reset();
        wm_thresh = LW'(3);
        chk("R10 wm_req level 0 thresh 3", 32'(wm_req), 32'd1);
        push(32'hA); push(32'hB); push(32'hC);
        chk("R10 wm_req level 3 thresh 3", 32'(wm_req), 32'd1);
        repeat (40) @(negedge clk);
        chk("R13 level kept while disabled", 32'(fifo_level), 32'd3);
        chk("R13 sck low while disabled", 32'(sck), 32'd0);
        chk("R13 ws high while disabled", 32'(ws), 32'd1);
        push(32'hD);
        chk("R10 wm_req level 4 thresh 3", 32'(wm_req), 32'd0);

        // R12: back-pressure at full
        for (int k = 0; k < 4; k++) push(32'h100 + 32'(k));
        chk("R12 level at full", 32'(fifo_level), 32'(DEPTH));
        chk("R12 in_ready low at full", 32'(in_ready), 32'd0);
        push(32'hBAD);
        chk("R12 level unchanged by refused word", 32'(fifo_level), 32'(DEPTH));

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule